// File: doc/BRIEF.md
# Buffered Signed PWM Period Counter

This block is one period generator of a PWM unit. A 16-bit signed up-counter starts at a programmable start value and counts up to a programmable limit. When it reaches the limit, it reloads the start value. Two compare points drive two registered outputs:

- a mid-period threshold sets the auxiliary PWM output and clears the local sync signal;
- the limit clears the auxiliary output, raises the local sync signal and issues a one-cycle reload strobe.

Software programs three value registers (start, threshold, limit) through a small write/read port. Writes land in shadow buffers. A commit flag moves the shadows into the active registers as one set. In deferred mode the move happens at the next full-period reload. In immediate mode it happens in the same cycle the commit is requested. While a commit is pending, writes to the value registers are locked out, so the set that lands is the set that was committed. A clock enable pauses counting.

Top module: `pwm_sub_counter`

## Requirements
- R1: After reset the counter reads 0, all shadow and active registers are 0, the commit flag and mode bit are 0, and `pwmx`, `lsync` and `reload` are 0.
- R2: On each cycle with `cnt_en` high, the counter advances by one in 16-bit signed arithmetic. When it equals the active limit, its next value is the start value instead. That start value is the newly committed shadow start if a deferred commit takes effect on that edge, and the active start otherwise.
- R3: On the edge where the counter equals the active limit with `cnt_en` high, `lsync` becomes 1 and `pwmx` becomes 0, and `reload` is 1 for exactly that following cycle.
- R4: On an enabled edge where the counter equals the active threshold but not the limit, `pwmx` becomes 1 and `lsync` becomes 0.
- R5: Writes to address 0 (start), 1 (threshold) and 2 (limit) change only the shadow registers. Counter behaviour is unchanged until a commit takes effect.
- R6: Writing address 3 with bit0=1 and bit1=0 sets the commit flag. The shadows are copied to the active set on the next enabled reload edge, and the flag clears on that same edge.
- R7: Writing address 3 with bit0=1 and bit1=1 copies the shadows to the active set on that edge, and the commit flag reads 0 afterwards. Every write to address 3 stores bit1 as the mode bit.
- R8: While the commit flag is 1, writes to addresses 0, 1 and 2 are ignored.
- R9: `reg_rdata` returns the shadow register selected by `reg_addr`. Address 3 returns the mode bit in bit1 and the commit flag in bit0, with the other bits zero.
- R10: While `cnt_en` is 0, the counter, `pwmx` and `lsync` hold their values, `reload` is 0, and no deferred commit takes effect.
- R11: A threshold outside the start-to-limit range never matches, so `pwmx` stays 0 for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter clock enable |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 start, 1 threshold, 2 limit, 3 control) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (shadow values or control) |
| cnt | output | 16 | Current signed counter value |
| pwmx | output | 1 | Auxiliary PWM output |
| lsync | output | 1 | Local sync signal |
| reload | output | 1 | One-cycle full-period reload strobe |

## Verification
The assertions check four things on every cycle:

- `pwmx` and `lsync` are never high together;
- a reload strobe always comes with `lsync` high;
- a pending commit clears on the reload edge that applies it;
- a locked threshold write leaves the shadow unchanged, and a disabled counter holds its value.

Only the bench scenarios can show the rest. That includes when a committed set actually takes effect in deferred versus immediate mode, that the counter reloads with the right start value, and that the threshold and limit compare correctly for negative ranges and out-of-range thresholds. For these, a behavioural model runs beside the design and is compared with it every cycle.

// File: rtl/pwm_sub_counter.sv
module pwm_sub_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         reg_wen,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] cnt,
  output logic         pwmx,
  output logic         lsync,
  output logic         reload
);

  logic signed [W-1:0] init_sh, mid_sh, max_sh;
  logic signed [W-1:0] init_act, mid_act, max_act;
  logic signed [W-1:0] cnt_q;
  logic ldok, ldmode;

  wire at_max   = (cnt_q == max_act);
  wire at_mid   = (cnt_q == mid_act);
  wire ctrl_wr  = reg_wen && (reg_addr == 2'd3);
  wire xfer_rel = ldok && cnt_en && at_max;
  wire xfer_imm = ctrl_wr && reg_wdata[0] && reg_wdata[1];
  wire xfer     = xfer_rel || xfer_imm;
  wire val_wr   = reg_wen && (reg_addr != 2'd3) && !ldok;

  assign cnt = cnt_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = init_sh;
      2'd1:    reg_rdata = mid_sh;
      2'd2:    reg_rdata = max_sh;
      default: reg_rdata = {{(W-2){1'b0}}, ldmode, ldok};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_sh <= '0; mid_sh <= '0; max_sh <= '0;
      init_act <= '0; mid_act <= '0; max_act <= '0;
      ldok <= 1'b0; ldmode <= 1'b0;
    end else begin
      if (val_wr) begin
        case (reg_addr)
          2'd0:    init_sh <= reg_wdata;
          2'd1:    mid_sh  <= reg_wdata;
          default: max_sh  <= reg_wdata;
        endcase
      end
      if (ctrl_wr) ldmode <= reg_wdata[1];
      if (xfer) begin
        init_act <= init_sh;
        mid_act  <= mid_sh;
        max_act  <= max_sh;
        ldok     <= 1'b0;
      end else if (ctrl_wr && reg_wdata[0]) begin
        ldok <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; pwmx <= 1'b0; lsync <= 1'b0; reload <= 1'b0;
    end else if (cnt_en) begin
      if (at_max) begin
        cnt_q  <= xfer_rel ? init_sh : init_act;
        reload <= 1'b1;
        lsync  <= 1'b1;
        pwmx   <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        reload <= 1'b0;
        if (at_mid) begin
          pwmx  <= 1'b1;
          lsync <= 1'b0;
        end
      end
    end else begin
      reload <= 1'b0;
    end
  end

  p_excl_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwmx && lsync));
  p_reload_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> lsync);
  p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ldok && cnt_en && cnt_q == max_act) |=> !ldok);
  p_locked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ldok && reg_wen && reg_addr == 2'd1) |=> $stable(mid_sh));
  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt_q) && !reload));

endmodule

// File: tb/test_pwm_sub_counter.sv
module test_pwm_sub_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic reg_wen = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, cnt;
  logic pwmx, lsync, reload;

  int total = 0;
  int bad = 0;
  int m_ish, m_msh, m_xsh, m_ia, m_ma, m_xa, m_cnt;
  bit m_ldok, m_mode, m_pwmx, m_sync, m_rel;
  int pwmx_high;

  always #10 clk = ~clk;

  pwm_sub_counter i_pwm_sub_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt(cnt), .pwmx(pwmx), .lsync(lsync), .reload(reload));

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int wrap(input int v);
    return ((v + 32768) % 65536) - 32768;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_rd();
    case (reg_addr)
      2'd0: return m_ish;
      2'd1: return m_msh;
      2'd2: return m_xsh;
      default: return (int'(m_mode) << 1) | int'(m_ldok);
    endcase
  endfunction

  task automatic model_step();
    bit ctrl_wr, xrel, ximm;
    int nish, nmsh, nxsh;
    ctrl_wr = reg_wen && reg_addr == 2'd3;
    xrel = m_ldok && cnt_en && (m_cnt == m_xa);
    ximm = ctrl_wr && reg_wdata[0] && reg_wdata[1];
    nish = m_ish; nmsh = m_msh; nxsh = m_xsh;
    if (reg_wen && reg_addr != 2'd3 && !m_ldok) begin
      if (reg_addr == 2'd0) nish = s16(reg_wdata);
      else if (reg_addr == 2'd1) nmsh = s16(reg_wdata);
      else nxsh = s16(reg_wdata);
    end
    if (cnt_en) begin
      if (m_cnt == m_xa) begin
        m_cnt = xrel ? m_ish : m_ia;
        m_rel = 1; m_sync = 1; m_pwmx = 0;
      end else begin
        if (m_cnt == m_ma) begin m_pwmx = 1; m_sync = 0; end
        m_cnt = wrap(m_cnt + 1);
        m_rel = 0;
      end
    end else m_rel = 0;
    if (ctrl_wr) m_mode = reg_wdata[1];
    if (xrel || ximm) begin
      m_ia = m_ish; m_ma = m_msh; m_xa = m_xsh; m_ldok = 0;
    end else if (ctrl_wr && reg_wdata[0]) m_ldok = 1;
    m_ish = nish; m_msh = nmsh; m_xsh = nxsh;
  endtask

  task automatic model_reset();
    m_ish = 0; m_msh = 0; m_xsh = 0; m_ia = 0; m_ma = 0; m_xa = 0; m_cnt = 0;
    m_ldok = 0; m_mode = 0; m_pwmx = 0; m_sync = 0; m_rel = 0;
  endtask

  task automatic compare();
    chk("R2 cnt", s16(cnt), m_cnt);
    chk("R4 pwmx", int'(pwmx), int'(m_pwmx));
    chk("R3 lsync", int'(lsync), int'(m_sync));
    chk("R3 reload", int'(reload), int'(m_rel));
    chk("R9 rdata", s16(reg_rdata), m_rd());
    if (pwmx) pwmx_high++;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    reg_wen = 1'b0;
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = 16'(d);
    cyc();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 cnt", s16(cnt), 0);
    chk("R1 pwmx", int'(pwmx), 0);
    chk("R1 lsync", int'(lsync), 0);
    chk("R1 reload", int'(reload), 0);
    reg_addr = 2'd3; #1;
    chk("R1 ctrl", s16(reg_rdata), 0);
    reg_addr = 2'd2; #1;
    chk("R1 limit", s16(reg_rdata), 0);

    cnt_en = 1'b1;
    run(3);
    // R5: shadows written, active unchanged
    wr(2'd0, -3); wr(2'd1, 0); wr(2'd2, 4);
    run(4);
    chk("R5 cnt still zero", s16(cnt), 0);
    reg_addr = 2'd0; #1;
    chk("R5 start shadow", s16(reg_rdata), -3);
    // R6: deferred commit
    wr(2'd3, 1);
    reg_addr = 2'd3; cyc();
    chk("R6 flag cleared after reload", s16(reg_rdata), 0);
    run(20);

    // R8: locked writes while pending
    wr(2'd1, 2);
    cnt_en = 1'b0;
    wr(2'd3, 1);
    wr(2'd1, 7);
    wr(2'd2, 9);
    reg_addr = 2'd1; cyc();
    chk("R8 threshold locked", s16(reg_rdata), 2);
    // R10: disabled counter holds, no commit
    run(5);
    reg_addr = 2'd3; cyc();
    chk("R10 flag still set", s16(reg_rdata), 1);
    cnt_en = 1'b1;
    run(20);
    for (int i = 0; i < 12; i++) begin
      cnt_en = (i % 3) != 0;
      cyc();
    end
    cnt_en = 1'b1;

    // R7 + R11: immediate commit with out-of-range threshold
    wr(2'd0, -2); wr(2'd1, 10); wr(2'd2, 5);
    wr(2'd3, 3);
    reg_addr = 2'd3; #1;
    chk("R7 flag zero after immediate", s16(reg_rdata), 2);
    run(8);
    pwmx_high = 0;
    run(24);
    chk("R11 pwmx never high", pwmx_high, 0);

    // negative range, deferred again (mode bit cleared)
    wr(2'd0, -10); wr(2'd1, -7); wr(2'd2, -4);
    wr(2'd3, 1);
    run(30);
    // R2 wrap: start near positive extreme
    wr(2'd0, 32765); wr(2'd1, -32767); wr(2'd2, -32765);
    wr(2'd3, 3);
    run(30);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule